// File: doc/BRIEF.md
# FPGA serial configuration sequencer

This block loads a configuration bitstream into an FPGA that takes its configuration over a serial clock and data pair. After a start request it first looks at the target's configured flag. If that flag is already high, the block reports success at once and does nothing else. Otherwise it pulses the target's PROGRAM control through a timed on, off, on sequence. It then waits until the target's INIT line is high, and streams a fixed number of bytes from a byte-wide memory read port onto CCLK and DIN. Last, it waits for the target's DONE line.

A host pulses `start_i` and watches `busy_o`. Completion is reported with a one-cycle `done_o`, and a timeout with a one-cycle `err_o`. The memory port issues a single-cycle read strobe with an address, and expects the data together with a valid strobe exactly one cycle later. The next byte is prefetched while the current one is shifting, so CCLK runs without gaps for the whole stream. INIT and DONE pass through two-flop synchronizers before the state machine uses them.

Top module: `fpga_serial_loader`

## Requirements
- R1: When `start_i` is accepted while the synchronized `cfg_done_i` is high, `done_o` pulses within four cycles. No memory read is issued and `prog_o` never goes high.
- R2: Otherwise `prog_o` is 1 for exactly DELAY_CYC cycles, then 0 for exactly DELAY_CYC cycles, then 1 until the run ends. It is 0 whenever the block is idle.
- R3: No memory read is issued while `init_i` is low after the PROGRAM pulse. INIT is sampled again every DELAY_CYC cycles, so the first read follows the rise of INIT by at most DELAY_CYC plus a few synchronizer cycles.
- R4: Exactly NUM_BYTES reads are issued at consecutive addresses BASE_ADDR, BASE_ADDR+1, and so on. Each read strobe lasts one cycle and has at most one read outstanding.
- R5: Each byte leaves least significant bit first. The value of `din_o` at every rising edge of `cclk_o` is the next bit, and a byte enters the shifter only when its holding buffer is empty.
- R6: Each half period of `cclk_o` lasts CLK_HZ/(2*CCLK_HZ) system cycles, and `din_o` changes only while `cclk_o` is low. The first and last rising edges of a stream are (8*NUM_BYTES-1) CCLK periods apart, with no gap at byte boundaries.
- R7: `done_o` is raised only after `cfg_done_i` has risen, and never while `cfg_done_i` is still low after the last byte.
- R8: If INIT stays low for INIT_TMO cycles, `err_o` pulses, no read is issued, and the block returns to idle with `prog_o` 0.
- R9: If DONE stays low for DONE_TMO cycles after the stream, `err_o` pulses and the block returns to idle with `prog_o` 0.
- R10: After reset `busy_o`, `done_o`, `err_o`, `prog_o`, `cclk_o`, `din_o` and `mem_rd_o` are all 0.
- R11: `busy_o` is high from an accepted start until the run ends, and `done_o` and `err_o` never pulse together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_valid_i | input | 1 | Read data valid, one cycle after the strobe |
| mem_data_i | input | 8 | Read data byte |
| prog_o | output | 1 | PROGRAM control, 1 = asserted |
| init_i | input | 1 | Target INIT line, asynchronous |
| cfg_done_i | input | 1 | Target DONE line, asynchronous |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |

## Verification
The bench builds the block with a six-byte stream, an eight-cycle PROGRAM interval, a two-cycle CCLK half period and timeouts of a little over a hundred cycles. This puts full runs, both timeout paths and repeated INIT re-checks within a few hundred cycles each, where the default 169216-byte image would need millions of cycles. The small base address and byte count let every address and every shifted bit of each run be compared against expected memory contents, under random INIT and DONE latencies.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P_ON,
    ST_P_OFF,
    ST_W_INIT,
    ST_STREAM,
    ST_W_DONE
  } fsl_state_e;
endpackage

// File: rtl/fsl_sync2.sv
module fsl_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
  parameter int unsigned HALF_DIV = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       empty_o,
  output logic       idle_o,
  output logic       cclk_o,
  output logic       din_o
);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);

  logic             active_q, cclk_q, buf_full_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, buf_q;
  logic             tick, consume;

  assign tick    = (div_q == DIV_W'(HALF_DIV - 1));
  // holding buffer moves into the shifter at start or at the last falling edge
  assign consume = buf_full_q && (!active_q || (tick && cclk_q && bit_q == 3'd7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
    end else begin
      if (load_i) begin
        buf_q      <= data_i;
        buf_full_q <= 1'b1;
      end else if (consume) begin
        buf_full_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cclk_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (!active_q) begin
      div_q  <= '0;
      cclk_q <= 1'b0;
      if (consume) begin
        active_q <= 1'b1;
        sh_q     <= buf_q;
        bit_q    <= '0;
      end
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          cclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            if (consume) begin
              sh_q  <= buf_q;
              bit_q <= '0;
            end else begin
              active_q <= 1'b0;
            end
          end else begin
            sh_q  <= {1'b0, sh_q[7:1]};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign empty_o = !buf_full_q;
  assign idle_o  = !active_q && !buf_full_q;
  assign cclk_o  = cclk_q;
  assign din_o   = active_q & sh_q[0];

  p_load_when_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> empty_o);
  p_din_stable_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_q) |-> $stable(din_o));
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
  import fsl_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned CCLK_HZ   = 12_500_000,
  parameter int unsigned DELAY_CYC = 1000,
  parameter int unsigned INIT_TMO  = 1_000_000,
  parameter int unsigned DONE_TMO  = 10_000_000,
  parameter int unsigned NUM_BYTES = 169216,
  parameter int unsigned ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              prog_o,
  input  logic              init_i,
  input  logic              cfg_done_i,
  output logic              cclk_o,
  output logic              din_o
);
  localparam int unsigned HALF_DIV = CLK_HZ / (2 * CCLK_HZ);
  localparam int unsigned DLY_W    = $clog2(DELAY_CYC + 1);
  localparam int unsigned CNT_W    = $clog2(NUM_BYTES + 1);
  localparam int unsigned TMO_MAX  = (INIT_TMO > DONE_TMO) ? INIT_TMO : DONE_TMO;
  localparam int unsigned TMO_W    = $clog2(TMO_MAX + 1);

  fsl_state_e       state_q;
  logic [DLY_W-1:0] dly_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CNT_W-1:0] rd_cnt_q;
  logic             pend_q, prog_q, done_q, err_q;
  logic             init_s, done_s, tx_empty, sh_idle, load;

  fsl_sync2 u_sync_init (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(init_i),     .q_o(init_s));
  fsl_sync2 u_sync_done (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(cfg_done_i), .q_o(done_s));

  fsl_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (mem_data_i),
    .empty_o(tx_empty),
    .idle_o (sh_idle),
    .cclk_o (cclk_o),
    .din_o  (din_o)
  );

  assign mem_rd_o   = (state_q == ST_STREAM) && tx_empty && !pend_q
                      && (rd_cnt_q != CNT_W'(NUM_BYTES));
  assign mem_addr_o = BASE_ADDR + ADDR_W'(rd_cnt_q);
  assign load       = mem_valid_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dly_q    <= '0;
      tmo_q    <= '0;
      rd_cnt_q <= '0;
      pend_q   <= 1'b0;
      prog_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (done_s) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_P_ON;
            prog_q  <= 1'b1;
            dly_q   <= DLY_W'(DELAY_CYC - 1);
          end
        end
        ST_P_ON: begin
          if (dly_q == '0) begin
            prog_q  <= 1'b0;
            state_q <= ST_P_OFF;
            dly_q   <= DLY_W'(DELAY_CYC - 1);
          end else dly_q <= dly_q - 1'b1;
        end
        ST_P_OFF: begin
          if (dly_q == '0) begin
            prog_q  <= 1'b1;
            state_q <= ST_W_INIT;
            tmo_q   <= '0;
          end else dly_q <= dly_q - 1'b1;
        end
        ST_W_INIT: begin
          if (dly_q == '0 && init_s) begin
            state_q  <= ST_STREAM;
            rd_cnt_q <= '0;
            pend_q   <= 1'b0;
          end else if (tmo_q == TMO_W'(INIT_TMO - 1)) begin
            err_q   <= 1'b1;
            prog_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
            dly_q <= (dly_q == '0) ? DLY_W'(DELAY_CYC - 1) : dly_q - 1'b1;
          end
        end
        ST_STREAM: begin
          if (mem_rd_o) begin
            pend_q   <= 1'b1;
            rd_cnt_q <= rd_cnt_q + 1'b1;
          end else if (load) begin
            pend_q <= 1'b0;
          end
          if (rd_cnt_q == CNT_W'(NUM_BYTES) && !pend_q && sh_idle) begin
            state_q <= ST_W_DONE;
            tmo_q   <= '0;
          end
        end
        ST_W_DONE: begin
          if (done_s) begin
            done_q  <= 1'b1;
            prog_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (tmo_q == TMO_W'(DONE_TMO - 1)) begin
            err_q   <= 1'b1;
            prog_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else tmo_q <= tmo_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign prog_o = prog_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  p_skip_configured_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && done_s) |=> (done_o && !prog_o && !busy_o));
  p_idle_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !prog_o);
  p_single_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  p_done_after_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(done_s));
  p_excl_pulses_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

// File: tb/fpga_serial_loader_tb.sv
`timescale 1ns/1ps
module fpga_serial_loader_tb;
  localparam int unsigned DLY   = 8;
  localparam int unsigned NB    = 6;
  localparam int unsigned HALF  = 2;
  localparam int unsigned ITMO  = 120;
  localparam int unsigned DTMO  = 150;
  localparam logic [15:0] BASE  = 16'h0100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, init_i = 1'b0, cfg_done_i = 1'b0;
  logic mem_valid_i = 1'b0;
  logic [7:0] mem_data_i = '0;
  logic busy_o, done_o, err_o, mem_rd_o, prog_o, cclk_o, din_o;
  logic [15:0] mem_addr_o;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] salt = 8'h00;

  always #4 clk = ~clk;

  fpga_serial_loader #(
    .CLK_HZ(125_000_000), .CCLK_HZ(31_250_000), .DELAY_CYC(DLY),
    .INIT_TMO(ITMO), .DONE_TMO(DTMO), .NUM_BYTES(NB), .ADDR_W(16), .BASE_ADDR(BASE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .prog_o(prog_o),
    .init_i(init_i), .cfg_done_i(cfg_done_i), .cclk_o(cclk_o), .din_o(din_o)
  );

  function automatic logic [7:0] mem_byte(logic [15:0] a, logic [7:0] s);
    return 8'(a * 37) ^ 8'(a >> 3) ^ s;
  endfunction

  // monitor and memory model, sampled on the falling system edge
  int rises = 0, bytes_n = 0, rds = 0, rd_low_init = 0, dones = 0, errs = 0, prog_hi = 0;
  int rise_cyc [64];
  logic [7:0]  byte_log [16];
  logic [15:0] rd_addr_log [16];
  int rd_cyc_log [16];
  logic cclk_prev = 1'b0, rd_prev = 1'b0;
  logic [15:0] addr_prev = '0;
  logic [7:0] shcap = '0;
  int bitn = 0;

  always @(negedge clk) begin
    cyc++;
    mem_valid_i = rd_prev;
    mem_data_i  = mem_byte(addr_prev, salt);
    rd_prev     = mem_rd_o;
    addr_prev   = mem_addr_o;
    if (mem_rd_o) begin
      rd_addr_log[rds % 16] = mem_addr_o;
      rd_cyc_log[rds % 16]  = cyc;
      if (!init_i) rd_low_init++;
      rds++;
    end
    if (cclk_o && !cclk_prev) begin
      rise_cyc[rises % 64] = cyc;
      rises++;
      shcap = {din_o, shcap[7:1]};
      bitn++;
      if (bitn == 8) begin
        byte_log[bytes_n % 16] = shcap;
        bytes_n++;
        bitn = 0;
      end
    end
    cclk_prev = cclk_o;
    if (done_o) dones++;
    if (err_o) errs++;
    if (prog_o) prog_hi++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // runs the PROGRAM sequence and checks both timed phases
  task automatic prog_phases();
    int n;
    n = 0;
    while (prog_o && n < 100) begin n++; @(negedge clk); end
    chk(n == DLY, "R2", "asserted phase length", n, DLY);
    chk(busy_o == 1'b1, "R11", "busy during run", busy_o, 1);
    n = 0;
    while (!prog_o && n < 100) begin n++; @(negedge clk); end
    chk(n == DLY, "R2", "released phase length", n, DLY);
  endtask

  task automatic full_load(input int init_lat, input int done_lat, input bit give_done);
    int r0, b0, a0, d0, e0, w0, t_init, n;
    r0 = rises; b0 = bytes_n; a0 = rds; d0 = dones; e0 = errs; w0 = rd_low_init;
    cfg_done_i = 1'b0; init_i = 1'b0;
    repeat (4) @(negedge clk);
    pulse_start();
    prog_phases();
    repeat (init_lat) @(negedge clk);
    init_i = 1'b1;
    t_init = cyc;
    n = 0;
    while (rds == a0 && n < 200) begin n++; @(negedge clk); end
    chk(rd_low_init == w0, "R3", "reads while INIT low", rd_low_init - w0, 0);
    chk(rds > a0 && rd_cyc_log[a0 % 16] - t_init <= int'(DLY) + 5, "R3", "first read latency",
        rd_cyc_log[a0 % 16] - t_init, DLY + 5);
    n = 0;
    while (bytes_n < b0 + NB && n < 2000) begin n++; @(negedge clk); end
    for (int i = 0; i < NB; i++) begin
      chk(rd_addr_log[(a0 + i) % 16] == BASE + 16'(i), "R4", "read address",
          rd_addr_log[(a0 + i) % 16], BASE + i);
      chk(byte_log[(b0 + i) % 16] == mem_byte(BASE + 16'(i), salt), "R5", "shifted byte",
          byte_log[(b0 + i) % 16], mem_byte(BASE + 16'(i), salt));
    end
    chk(rise_cyc[(r0 + 8*NB - 1) % 64] - rise_cyc[r0 % 64] == (8*NB - 1) * 2 * HALF, "R6",
        "stream span", rise_cyc[(r0 + 8*NB - 1) % 64] - rise_cyc[r0 % 64], (8*NB - 1) * 2 * HALF);
    chk(rise_cyc[(r0 + 1) % 64] - rise_cyc[r0 % 64] == 2 * HALF, "R6", "cclk period",
        rise_cyc[(r0 + 1) % 64] - rise_cyc[r0 % 64], 2 * HALF);
    repeat (done_lat) @(negedge clk);
    chk(rds - a0 == NB, "R4", "read count", rds - a0, NB);
    chk(dones == d0 && busy_o, "R7", "no done before DONE pin", dones - d0, 0);
    if (give_done) begin
      cfg_done_i = 1'b1;
      n = 0;
      while (dones == d0 && n < 40) begin n++; @(negedge clk); end
      chk(dones == d0 + 1 && errs == e0, "R7", "done pulse after DONE pin", dones - d0, 1);
      @(negedge clk);
      chk(!prog_o && !busy_o, "R2", "released after done", prog_o, 0);
    end else begin
      n = 0;
      while (errs == e0 && n < 400) begin n++; @(negedge clk); end
      chk(errs == e0 + 1 && dones == d0, "R9", "DONE timeout error", errs - e0, 1);
      @(negedge clk);
      chk(!prog_o && !busy_o, "R9", "idle after DONE timeout", prog_o, 0);
    end
  endtask

  initial begin
    int a0, d0, e0, p0, n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R10", "status after reset", busy_o, 0);
    chk(!prog_o, "R10", "prog after reset", prog_o, 0);
    chk(!cclk_o && !din_o, "R10", "serial pins after reset", cclk_o, 0);
    chk(!mem_rd_o, "R10", "read strobe after reset", mem_rd_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !prog_o && !cclk_o && !mem_rd_o, "R10", "idle after release", busy_o, 0);

    // R1: target already configured
    a0 = rds; d0 = dones; p0 = prog_hi;
    cfg_done_i = 1'b1;
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    chk(dones == d0 + 1, "R1", "immediate done", dones - d0, 1);
    chk(rds == a0 && prog_hi == p0, "R1", "no reads or PROGRAM", rds - a0 + prog_hi - p0, 0);
    chk(!busy_o, "R1", "stays idle", busy_o, 0);

    // directed: INIT already high, DONE immediately
    salt = 8'h00;
    full_load(0, 0, 1'b1);
    // directed: INIT late, needing several re-checks
    salt = 8'hA5;
    full_load(3 * DLY + 3, 20, 1'b1);

    // R8: INIT never rises
    a0 = rds; e0 = errs; d0 = dones;
    cfg_done_i = 1'b0; init_i = 1'b0;
    repeat (4) @(negedge clk);
    pulse_start();
    prog_phases();
    n = 0;
    while (errs == e0 && n < 300) begin n++; @(negedge clk); end
    chk(errs == e0 + 1 && dones == d0, "R8", "INIT timeout error", errs - e0, 1);
    chk(rds == a0, "R8", "no reads on INIT timeout", rds - a0, 0);
    @(negedge clk);
    chk(!prog_o && !busy_o, "R8", "idle after INIT timeout", prog_o, 0);

    // R9: DONE never rises
    salt = 8'h3C;
    full_load(5, 0, 1'b0);

    // random latencies and contents
    for (int k = 0; k < 4; k++) begin
      salt = 8'($urandom_range(0, 255));
      full_load(int'($urandom_range(0, 60)), int'($urandom_range(0, 100)), 1'b1);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule